// File: doc/BRIEF.md
# Request Class Packet Header Builder

This block turns one read or atomic transaction request into the logical-layer header of a Request class packet and sends that header one byte at a time on a valid/ready byte stream. A request carries a 4-bit transaction code, a 34-bit byte address, up to 32 bits of extra upper address, a read length in bytes, an 8-bit source transaction ID and an address-model select. The block packs the format type, the transaction code, a size code, the ID, an optional address extension and a 32-bit address word that holds a double-word address, a word pointer and two extra high address bits. It then pads the header with zero bytes to a multiple of eight.

Before accepting a request for transmission, the block checks the transaction code, the address model and the length and alignment rules. A request that breaks any of them is consumed without emitting a byte, and a one-cycle error pulse follows. While a header is being sent, no new request is taken.

Top module: `reqHdrBuilder`

## Requirements
- R1: Byte 0 of every header is {4'h2, transaction code}: the upper nibble is the fixed format type 2 and the lower nibble is the request's transaction code.
- R2: Only the transaction codes 4'b0100 (read), 4'b1100 (atomic increment), 4'b1101 (atomic decrement), 4'b1110 (atomic set) and 4'b1111 (atomic clear) are sent. Any other code is refused with an error pulse, and no byte is emitted.
- R3: Byte 1 is {size code[3:0], ID[7:4]}. Byte 2 is {ID[3:0], 4'b0000}.
- R4: The address word is 32 bits, sent most significant byte first, and laid out as {byte address[31:3], word pointer, byte address[33:32]}. So bits 31:3 hold the 29-bit double-word address, bit 2 holds the word pointer and bits 1:0 hold the two extra high address bits.
- R5: The address model select 0 (small) adds no extension. Select 1 (medium) inserts extension bits [15:0] as 2 bytes. Select 2 (large) inserts extension bits [31:0] as 4 bytes. Each extension is sent most significant byte first, right after byte 2 and before the address word. Select 3 is refused with an error pulse.
- R6: After the address word, zero bytes fill the header to 8 bytes (small model) or 16 bytes (medium or large model). The last-byte flag is high exactly on the final byte.
- R7: For lengths of 1, 2 or 4 bytes, with byte offset o = address[2:0], the size code is {2'b00, o[1:0]} for 1 byte, {3'b010, o[1]} for 2 bytes and 4'b0110 for 4 bytes. The word pointer is o[2].
- R8: A length of 8 bytes or fewer is accepted only if it is 1, 2, 4 or 8 bytes and the offset is a multiple of the length. Any other short request is refused with an error pulse.
- R9: A length of 8 to 256 bytes is accepted only if the offset is 0 and the length is 8 times a power of two. Its size code is 8 + log2(length/8) and its word pointer is 0. A length of 0, a length above 256, and any other length above 8 are refused with an error pulse.
- R10: Request-ready stays low from the cycle after a request is accepted for sending until the last header byte has been accepted downstream. It is high again in the following cycle.
- R11: While output-valid is high and output-ready is low, output-valid stays high and the output byte does not change.
- R12: A refused request is consumed (request-ready is high when it is offered). The error pulse is high for exactly the one cycle after acceptance, and output-valid stays low.
- R13: After reset, request-ready is high, and output-valid and the error pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken |
| reqType | input | 4 | Transaction code |
| reqAddr | input | 34 | Byte address |
| reqExt | input | 32 | Extension address bits for the medium and large models |
| reqLen | input | 9 | Requested length in bytes |
| reqTid | input | 8 | Source transaction ID |
| addrModel | input | 2 | Address model: 0 small, 1 medium, 2 large |
| outValid | output | 1 | Header byte valid |
| outReady | input | 1 | Downstream takes the byte |
| outData | output | 8 | Header byte |
| outLast | output | 1 | Final byte of the header |
| errPulse | output | 1 | One-cycle pulse for a refused request |

## Verification
The hardest situations to reach from the ports are the ones where size encoding and stalls interact. One is a short request whose offset is legal for its length but places the data in the upper word, so the word pointer and the low size bits must both be right. The other is a long request that stalls on the final pad byte. The bench sweeps every length from 0 to 511 against every byte offset, and every transaction code against every address model. Downstream ready follows a pseudo-random pattern, so stalls land on every byte position, including the one that ends a 16-byte header.

// File: rtl/reqHdrPkg.sv
package reqHdrPkg;
  localparam int ADDR_W     = 34;
  localparam int EXT_W      = 32;
  localparam int LEN_W      = 9;
  localparam int TID_W      = 8;
  localparam int CODE_W     = 4;
  localparam int IDX_W      = 4;
  localparam int BASE_BYTES = 3;
  localparam int ADDR_BYTES = 4;
  localparam int SMALL_HDR  = 8;
  localparam int BIG_HDR    = 16;
  localparam logic [CODE_W-1:0] FMT_TYPE = 4'h2;

  localparam logic [1:0] MODEL_SMALL  = 2'd0;
  localparam logic [1:0] MODEL_MEDIUM = 2'd1;
  localparam logic [1:0] MODEL_LARGE  = 2'd2;

  typedef struct packed {
    logic load;
    logic step;
  } hdrStrobe_t;

  typedef struct packed {
    logic              ok;
    logic [CODE_W-1:0] code;
    logic              wordPtr;
  } sizeInfo_t;

  function automatic logic typeAllowed(input logic [CODE_W-1:0] t);
    return (t == 4'b0100) || (t[3:2] == 2'b11);
  endfunction

  function automatic sizeInfo_t encodeSize(input logic [LEN_W-1:0] len,
                                           input logic [2:0] off);
    sizeInfo_t s;
    s = '0;
    case (len)
      9'd1:   begin s.ok = 1'b1;            s.code = {2'b00, off[1:0]}; s.wordPtr = off[2]; end
      9'd2:   begin s.ok = !off[0];         s.code = {3'b010, off[1]};  s.wordPtr = off[2]; end
      9'd4:   begin s.ok = (off[1:0] == 0); s.code = 4'b0110;           s.wordPtr = off[2]; end
      9'd8:   begin s.ok = (off == 0);      s.code = 4'b1000; end
      9'd16:  begin s.ok = (off == 0);      s.code = 4'b1001; end
      9'd32:  begin s.ok = (off == 0);      s.code = 4'b1010; end
      9'd64:  begin s.ok = (off == 0);      s.code = 4'b1011; end
      9'd128: begin s.ok = (off == 0);      s.code = 4'b1100; end
      9'd256: begin s.ok = (off == 0);      s.code = 4'b1101; end
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/reqHdrCtrl.sv
module reqHdrCtrl
  import reqHdrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqType,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [2:0]        reqOff,
  input  logic [1:0]        addrModel,
  input  logic              outReady,
  input  logic              lastByte,
  output logic              reqReady,
  output logic              outValid,
  output logic              errPulse,
  output hdrStrobe_t        strobe,
  output logic [CODE_W-1:0] sizeCode,
  output logic              wordPtr
);
  typedef enum logic {S_IDLE, S_SEND} state_t;
  state_t state, stateNext;

  sizeInfo_t sz;
  logic accept, bad;

  assign sz       = encodeSize(reqLen, reqOff);
  assign sizeCode = sz.code;
  assign wordPtr  = sz.wordPtr;
  assign reqReady = (state == S_IDLE);
  assign outValid = (state == S_SEND);
  assign accept   = reqValid && reqReady;
  assign bad      = !typeAllowed(reqType) || (addrModel == 2'd3) || !sz.ok;

  assign strobe.load = accept && !bad;
  assign strobe.step = outValid && outReady && !lastByte;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE: if (accept && !bad) stateNext = S_SEND;
      S_SEND: if (outReady && lastByte) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      errPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      errPulse <= accept && bad;
    end
  end

  // R12
  err_no_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !outValid);

  // R10
  done_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> $past(outReady && lastByte));

  // R11
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);
endmodule

// File: rtl/reqHdrData.sv
module reqHdrData
  import reqHdrPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  hdrStrobe_t          strobe,
  input  logic                sending,
  input  logic                outReady,
  input  logic [CODE_W-1:0]   reqType,
  input  logic [ADDR_W-1:3]   reqDwAddr,
  input  logic [EXT_W-1:0]    reqExt,
  input  logic [TID_W-1:0]    reqTid,
  input  logic [1:0]          addrModel,
  input  logic [CODE_W-1:0]   sizeCode,
  input  logic                wordPtr,
  output logic [7:0]          outData,
  output logic                lastByte
);
  logic [CODE_W-1:0] typeQ, sizeQ;
  logic              ptrQ;
  logic [TID_W-1:0]  tidQ;
  logic [ADDR_W-1:3] addrQ;
  logic [EXT_W-1:0]  extQ;
  logic [1:0]        modelQ;
  logic [IDX_W-1:0]  idxQ;

  logic [IDX_W-1:0]  extBytes, lastIdx, rel, extSel, addrSel;
  logic [31:0]       addrWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      typeQ  <= '0;
      sizeQ  <= '0;
      ptrQ   <= 1'b0;
      tidQ   <= '0;
      addrQ  <= '0;
      extQ   <= '0;
      modelQ <= MODEL_SMALL;
      idxQ   <= '0;
    end else if (strobe.load) begin
      typeQ  <= reqType;
      sizeQ  <= sizeCode;
      ptrQ   <= wordPtr;
      tidQ   <= reqTid;
      addrQ  <= reqDwAddr;
      extQ   <= reqExt;
      modelQ <= addrModel;
      idxQ   <= '0;
    end else if (strobe.step) begin
      idxQ   <= idxQ + 1'b1;
    end
  end

  always_comb begin
    case (modelQ)
      MODEL_MEDIUM: extBytes = 4'd2;
      MODEL_LARGE:  extBytes = 4'd4;
      default:      extBytes = 4'd0;
    endcase
  end

  assign lastIdx  = (modelQ == MODEL_SMALL) ? IDX_W'(SMALL_HDR - 1) : IDX_W'(BIG_HDR - 1);
  assign lastByte = (idxQ == lastIdx);
  assign addrWord = {addrQ[31:3], ptrQ, addrQ[ADDR_W-1:32]};
  assign rel      = idxQ - IDX_W'(BASE_BYTES);
  assign extSel   = extBytes - 4'd1 - rel;
  assign addrSel  = IDX_W'(ADDR_BYTES - 1) - (rel - extBytes);

  always_comb begin
    if (idxQ == 4'd0)                       outData = {FMT_TYPE, typeQ};
    else if (idxQ == 4'd1)                  outData = {sizeQ, tidQ[7:4]};
    else if (idxQ == 4'd2)                  outData = {tidQ[3:0], 4'h0};
    else if (rel < extBytes)                outData = 8'(extQ >> {extSel[1:0], 3'b000});
    else if ((rel - extBytes) < IDX_W'(ADDR_BYTES))
                                            outData = 8'(addrWord >> {addrSel[1:0], 3'b000});
    else                                    outData = 8'h00;
  end

  // R11
  stable_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    sending && !outReady |=> $stable(outData));

  // R6
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    sending |-> idxQ <= lastIdx);
endmodule

// File: rtl/reqHdrBuilder.sv
module reqHdrBuilder
  import reqHdrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqType,
  input  logic [33:0]       reqAddr,
  input  logic [31:0]       reqExt,
  input  logic [8:0]        reqLen,
  input  logic [7:0]        reqTid,
  input  logic [1:0]        addrModel,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outLast,
  output logic              errPulse
);
  hdrStrobe_t        strobe;
  logic [CODE_W-1:0] sizeCode;
  logic              wordPtr, lastByte;

  reqHdrCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqLen(reqLen), .reqOff(reqAddr[2:0]), .addrModel(addrModel),
    .outReady(outReady), .lastByte(lastByte), .reqReady(reqReady),
    .outValid(outValid), .errPulse(errPulse), .strobe(strobe),
    .sizeCode(sizeCode), .wordPtr(wordPtr)
  );

  reqHdrData i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sending(outValid),
    .outReady(outReady), .reqType(reqType), .reqDwAddr(reqAddr[ADDR_W-1:3]),
    .reqExt(reqExt), .reqTid(reqTid), .addrModel(addrModel),
    .sizeCode(sizeCode), .wordPtr(wordPtr), .outData(outData),
    .lastByte(lastByte)
  );

  assign outLast = outValid && lastByte;

  // R13
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> reqReady && !outValid && !errPulse);
endmodule

// File: tb/test_reqHdrBuilder.sv
module test_reqHdrBuilder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  reqType = '0;
  logic [33:0] reqAddr = '0;
  logic [31:0] reqExt = '0;
  logic [8:0]  reqLen = '0;
  logic [7:0]  reqTid = '0;
  logic [1:0]  addrModel = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outData;
  logic        outLast;
  logic        errPulse;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] expB [16];
  int         expN;
  bit         expBad;

  always #2 clk = ~clk;

  reqHdrBuilder i_reqHdrBuilder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqType(reqType), .reqAddr(reqAddr), .reqExt(reqExt), .reqLen(reqLen),
    .reqTid(reqTid), .addrModel(addrModel), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outLast(outLast),
    .errPulse(errPulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      testsFailed = testsFailed + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testsRun = testsRun + 1;
    if (!ok) begin
      testsFailed = testsFailed + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Expected header from the requirements, by arithmetic
  task automatic buildExpected(input int t, input longint addr, input longint ext,
                               input int len, input int tid, input int model);
    int off, rd, wp, p, e, dw;
    bit ok;
    longint aw;
    off = int'(addr % 8);
    ok = 0; rd = 0; wp = 0;
    if (len == 1 || len == 2 || len == 4) begin
      ok = (off % len) == 0;
      rd = (len == 1) ? off % 4 : (len == 2) ? 4 + (off % 4) / 2 : 6;
      wp = off / 4;
    end else if (len >= 8 && len <= 256 && len % 8 == 0 && off == 0) begin
      dw = len / 8;
      for (int k = 0; k < 6; k++) if (dw == (1 << k)) begin ok = 1; rd = 8 + k; end
    end
    expBad = !ok || model == 3 || !(t == 4 || t >= 12);
    expN = (model == 0) ? 8 : 16;
    for (int k = 0; k < 16; k++) expB[k] = 8'h00;
    expB[0] = 8'(32 + t);
    expB[1] = 8'(rd * 16 + tid / 16);
    expB[2] = 8'((tid % 16) * 16);
    p = 3;
    e = model * 2;
    for (int j = 0; j < e && model < 3; j++) begin
      expB[p] = 8'((ext >> (8 * (e - 1 - j))) & 255);
      p++;
    end
    aw = ((addr / 8) % (longint'(1) << 29)) * 8 + wp * 4 + addr / (longint'(1) << 32);
    for (int j = 0; j < 4; j++) begin
      if (p < 16) expB[p] = 8'((aw >> (8 * (3 - j))) & 255);
      p++;
    end
  endtask

  function automatic string tagFor(input int idx, input int model);
    if (idx == 0) return "R1";
    if (idx <= 2) return "R3 R7 R9";
    if (idx < 3 + 2 * model) return "R5";
    if (idx < 7 + 2 * model) return "R4";
    return "R6";
  endfunction

  task automatic runReq(input int t, input longint addr, input longint ext,
                        input int len, input int tid, input int model);
    int k;
    bit stalled;
    logic [7:0] held;
    buildExpected(t, addr, ext, len, tid, model);
    @(negedge clk);
    check(reqReady == 1'b1, "R10 ready before offer", reqReady, 1);
    reqValid = 1'b1; reqType = 4'(t); reqAddr = 34'(addr); reqExt = 32'(ext);
    reqLen = 9'(len); reqTid = 8'(tid); addrModel = 2'(model);
    @(negedge clk);
    reqValid = 1'b0;
    if (expBad) begin
      check(errPulse == 1'b1, "R2 R5 R8 R9 R12 error pulse", errPulse, 1);
      check(outValid == 1'b0, "R2 R12 no bytes", outValid, 0);
      @(negedge clk);
      check(errPulse == 1'b0, "R12 pulse width", errPulse, 0);
      check(outValid == 1'b0, "R2 R12 no bytes later", outValid, 0);
      return;
    end
    check(errPulse == 1'b0, "R12 no pulse on good request", errPulse, 0);
    k = 0;
    stalled = 0;
    held = '0;
    while (k < expN) begin
      check(reqReady == 1'b0, "R10 ready low while sending", reqReady, 0);
      check(outValid == 1'b1, "R11 valid held", outValid, 1);
      if (stalled) check(outData == held, "R11 byte stable under stall", outData, held);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = lfsr[0] | lfsr[1];
      if (outReady) begin
        check(outData == expB[k], tagFor(k, model), outData, expB[k]);
        check(outLast == (k == expN - 1), "R6 last flag", outLast, (k == expN - 1));
        k++;
        stalled = 0;
      end else begin
        stalled = 1;
        held = outData;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    check(reqReady == 1'b1, "R10 ready after last byte", reqReady, 1);
    check(outValid == 1'b0, "R6 no byte past end", outValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R13 reset ready", reqReady, 1);
    check(outValid == 1'b0, "R13 reset valid", outValid, 0);
    check(errPulse == 1'b0, "R13 reset error", errPulse, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && !outValid && !errPulse, "R13 idle after reset",
          {reqReady, outValid, errPulse}, 3'b100);

    // Sweep lengths 0..511 against every byte offset (R7 R8 R9)
    for (int len = 0; len < 512; len++) begin
      for (int off = 0; off < 8; off++) begin
        longint a;
        a = (longint'(len % 4) << 32) + longint'((len * 37 + off * 11) % 536870912) * 8 + off;
        runReq(4, a, 32'h5A3C_0F96 + len, len, (len * 7 + off) % 256, len % 3);
      end
    end

    // Sweep every code against every address model (R1 R2 R5)
    for (int t = 0; t < 16; t++) begin
      for (int m = 0; m < 4; m++) begin
        runReq(t, 34'h3_C001_2340 + t * 8, 32'h8142_C3E7 ^ (t * 4099), 8, t * 16 + m, m);
        runReq(t, 34'h1_7FFF_FFF6, 32'hFEDC_BA98, 2, 255 - t, m);
        runReq(t, 34'h2_0000_0100, 32'h0123_4567, 256, t, m);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule